// File: doc/BRIEF.md
# Binary Early/Late Phase Detector

This block is the decision stage of a clock and data recovery loop. Each cycle of the recovered clock it receives a beat of `LANES` bit periods. For each bit it gets two samples: one taken at the bit centre and one taken at the boundary just before that centre. A lane compares the boundary sample with the centre samples on either side of it. When those two centres differ, the boundary sample shows whether the recovered clock is late or early. When they match, the lane has no opinion.

The lane opinions are combined by a simple vote into one three-state charge-pump command: pump up, pump down or hold. The command is registered and presented on two pins. The detector gives only a binary lead/lag answer and never a measure of how large the phase error is. It holds the pump idle through transition-free data of any length. An enable pin lets an outside mode controller take the detector out of the loop. While the enable is low, the detector still keeps track of the data.

Beats arrive as a stream qualified by `beat_valid`. The detector has no ready output and never applies back-pressure: it accepts every beat that is presented with `beat_valid` high, in the cycle it is presented. A cycle with `beat_valid` low carries no samples.

Top module: `bangbang_pd`

## Requirements
- R1: A synchronous active-high `rst` clears the registered command to hold (both pump pins low) on the next clock edge. It also clears the stored previous-centre bit to 0 and marks the history as empty. A beat presented while `rst` is high has no effect.
- R2: Bit order in a beat: bit 0 is the earliest bit. Boundary bit i lies between centre bit i-1 and centre bit i. For bit 0, the preceding centre is bit `LANES-1` of the previous accepted beat. The command for a beat accepted at clock edge k appears on the pump pins after edge k and stays there until edge k+1.
- R3: A lane whose two surrounding centres differ, and whose boundary sample equals its own (newer) centre sample, casts an up vote (clock late).
- R4: A lane whose two surrounding centres differ, and whose boundary sample equals the older centre sample, casts a down vote (clock early).
- R5: A lane whose two surrounding centres are equal casts no vote. Any run of identical centre bits, of any length including more than 1000 bits, therefore yields only hold commands.
- R6: The beat command is up when there are more up votes than down votes, down when there are fewer, and hold when the counts are equal (including zero).
- R7: `pump_up` and `pump_dn` are never high in the same cycle.
- R8: A beat accepted while `en` is low yields hold. Its last centre bit is still stored as history for the next beat.
- R9: A cycle with `beat_valid` low yields hold and leaves the stored history unchanged.
- R10: In the first beat accepted after reset, bit 0 has no preceding centre and casts no vote. The other lanes of that beat vote normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Connects the detector to the loop when high |
| beat_valid | input | 1 | Qualifies the samples of this cycle |
| ctr_smp | input | LANES | Bit-centre samples, bit 0 earliest |
| bnd_smp | input | LANES | Boundary samples, bit i precedes centre bit i |
| pump_up | output | 1 | Charge-pump source command (clock late) |
| pump_dn | output | 1 | Charge-pump sink command (clock early) |

## Verification
Two functions can fall in the same cycle: a valid beat full of transitions and a low enable. That beat must produce hold and must also store its last centre bit as history. The bench provokes this by presenting a decisive beat with `en` low. It then sends, with `en` high, a beat whose bit 0 votes down only if that history was stored, and judges both cycles. The same pairing is applied to reset and a valid beat, and to a beat with `beat_valid` low. Each is followed by a beat whose result depends on which history the detector kept.

// File: rtl/bbpd_pkg.sv
package bbpd_pkg;

  typedef enum logic [1:0] {
    PUMP_HOLD = 2'b00,
    PUMP_UP   = 2'b01,
    PUMP_DN   = 2'b10
  } pump_cmd_t;

  typedef struct packed {
    logic up;
    logic dn;
  } lane_vote_t;

endpackage

// File: rtl/bbpd_history.sv
module bbpd_history (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic last_ctr,
  output logic prev_bit,
  output logic primed
);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_bit <= 1'b0;
      primed   <= 1'b0;
    end else if (take) begin
      prev_bit <= last_ctr;
      primed   <= 1'b1;
    end
  end

endmodule

// File: rtl/bbpd_lane.sv
module bbpd_lane
  import bbpd_pkg::*;
(
  input  logic       qualify,
  input  logic       older_ctr,
  input  logic       newer_ctr,
  input  logic       bnd,
  output lane_vote_t vote
);

  logic edge_seen;

  always_comb begin
    edge_seen = qualify && (older_ctr != newer_ctr);
    vote.up   = edge_seen && (bnd == newer_ctr);
    vote.dn   = edge_seen && (bnd == older_ctr);
  end

endmodule

// File: rtl/bbpd_tally.sv
module bbpd_tally
  import bbpd_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] up_v,
  input  logic [LANES-1:0] dn_v,
  output pump_cmd_t        cmd
);

  localparam int CW = $clog2(LANES + 1);

  logic [CW-1:0] up_cnt;
  logic [CW-1:0] dn_cnt;

  always_comb begin
    up_cnt = '0;
    dn_cnt = '0;
    for (int i = 0; i < LANES; i++) begin
      up_cnt = up_cnt + CW'(up_v[i]);
      dn_cnt = dn_cnt + CW'(dn_v[i]);
    end
    if (up_cnt > dn_cnt)      cmd = PUMP_UP;
    else if (dn_cnt > up_cnt) cmd = PUMP_DN;
    else                      cmd = PUMP_HOLD;
  end

endmodule

// File: rtl/bangbang_pd.sv
module bangbang_pd
  import bbpd_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             beat_valid,
  input  logic [LANES-1:0] ctr_smp,
  input  logic [LANES-1:0] bnd_smp,
  output logic             pump_up,
  output logic             pump_dn
);

  logic             hist_prev;
  logic             hist_primed;
  logic [LANES-1:0] up_v;
  logic [LANES-1:0] dn_v;
  pump_cmd_t        beat_cmd;
  pump_cmd_t        cmd_q;

  bbpd_history u_hist (
    .clk      (clk),
    .rst      (rst),
    .take     (beat_valid),
    .last_ctr (ctr_smp[LANES-1]),
    .prev_bit (hist_prev),
    .primed   (hist_primed)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_vote_t vote;
    if (g == 0) begin : g_first
      bbpd_lane u_lane (
        .qualify   (hist_primed),
        .older_ctr (hist_prev),
        .newer_ctr (ctr_smp[0]),
        .bnd       (bnd_smp[0]),
        .vote      (vote)
      );
    end else begin : g_rest
      bbpd_lane u_lane (
        .qualify   (1'b1),
        .older_ctr (ctr_smp[g-1]),
        .newer_ctr (ctr_smp[g]),
        .bnd       (bnd_smp[g]),
        .vote      (vote)
      );
    end
    assign up_v[g] = vote.up;
    assign dn_v[g] = vote.dn;
  end

  bbpd_tally #(.LANES(LANES)) u_tally (
    .up_v (up_v),
    .dn_v (dn_v),
    .cmd  (beat_cmd)
  );

  always_ff @(posedge clk) begin
    if (rst)                      cmd_q <= PUMP_HOLD;
    else if (beat_valid && en)    cmd_q <= beat_cmd;
    else                          cmd_q <= PUMP_HOLD;
  end

  assign pump_up = (cmd_q == PUMP_UP);
  assign pump_dn = (cmd_q == PUMP_DN);

endmodule

// File: rtl/bangbang_pd_chk.sv
module bangbang_pd_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic             beat_valid,
  input logic [LANES-1:0] ctr_smp,
  input logic             hist_prev,
  input logic             pump_up,
  input logic             pump_dn
);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!pump_up && !pump_dn));

  // R7
  pump_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(pump_up && pump_dn));

  // R8
  disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!pump_up && !pump_dn));

  // R9
  idle_beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !beat_valid |=> (!pump_up && !pump_dn));

  // R5
  flat_run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && ctr_smp == {LANES{hist_prev}}) |=> (!pump_up && !pump_dn));

endmodule

bind bangbang_pd bangbang_pd_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .beat_valid (beat_valid),
  .ctr_smp    (ctr_smp),
  .hist_prev  (hist_prev),
  .pump_up    (pump_up),
  .pump_dn    (pump_dn)
);

// File: tb/bangbang_pd_bench.sv
module bangbang_pd_bench;

  localparam int NL = 4;
  localparam int NV = 11;

  // row: {valid, ctr[3:0], bnd[3:0], exp_up, exp_dn}
  localparam logic [10:0] VEC [NV] = '{
    11'b1_0000_1111_0_0,  // R5 flat beat, no vote
    11'b1_1111_0000_0_1,  // R4 bit0 early
    11'b1_0000_0000_1_0,  // R3 bit0 late
    11'b1_0101_1111_0_0,  // R6 two up, two down: tie
    11'b1_0101_0101_1_0,  // R3 all lanes late
    11'b1_0101_1010_0_1,  // R4 all lanes early
    11'b1_0011_0001_1_0,  // R2 lane order, bits 0 and 2 late
    11'b1_1100_0000_0_1,  // R4 only bit 2 transitions, early
    11'b0_0000_0000_0_0,  // R9 idle cycle
    11'b1_1111_0000_0_0,  // R9 history kept across idle cycle
    11'b1_1010_0010_1_0   // R6 three up vs one down
  };
  localparam int REQ [NV] = '{5, 4, 3, 6, 3, 4, 2, 4, 9, 9, 6};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b1;
  logic          beat_valid = 1'b0;
  logic [NL-1:0] ctr_smp = '0;
  logic [NL-1:0] bnd_smp = '0;
  logic          pump_up;
  logic          pump_dn;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  bangbang_pd #(.LANES(NL)) u_bangbang_pd (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .beat_valid (beat_valid),
    .ctr_smp    (ctr_smp),
    .bnd_smp    (bnd_smp),
    .pump_up    (pump_up),
    .pump_dn    (pump_dn)
  );

  task automatic check(input string tag, input logic eu, input logic ed);
    n_chk++;
    if (pump_up !== eu || pump_dn !== ed) begin
      n_err++;
      $display("FAIL %s: up=%0b dn=%0b expected up=%0b dn=%0b",
               tag, pump_up, pump_dn, eu, ed);
    end
  endtask

  task automatic drive(input logic v, input logic e,
                       input logic [NL-1:0] c, input logic [NL-1:0] b);
    beat_valid = v;
    en         = e;
    ctr_smp    = c;
    bnd_smp    = b;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_err++;
    $display("FAIL watchdog: up=%0b dn=%0b expected run to finish", pump_up, pump_dn);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int run_bad;
    repeat (3) @(negedge clk);
    check("R1 reset state", 1'b0, 1'b0);
    rst = 1'b0;

    // R10: bit0 unprimed would vote down and tie the bit1 up vote
    drive(1'b1, 1'b1, 4'b0001, 4'b0000);
    check("R10 first beat bit0 ignored", 1'b1, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][10], 1'b1, VEC[i][9:6], VEC[i][5:2]);
      check($sformatf("R%0d table row %0d", REQ[i], i), VEC[i][1], VEC[i][0]);
    end

    // R8: decisive beat with enable low, history must still update to 0
    drive(1'b1, 1'b0, 4'b0000, 4'b0000);
    check("R8 enable low gives hold", 1'b0, 1'b0);
    drive(1'b1, 1'b1, 4'b1111, 4'b0000);
    check("R8 history stored while disabled", 1'b0, 1'b1);

    // R5: 300 flat beats = 1200 identical bits
    run_bad = 0;
    for (int i = 0; i < 300; i++) begin
      drive(1'b1, 1'b1, 4'b1111, 4'(i));
      if (pump_up || pump_dn) run_bad++;
    end
    n_chk++;
    if (run_bad != 0) begin
      n_err++;
      $display("FAIL R5 long run: nonhold=%0d expected nonhold=0", run_bad);
    end
    drive(1'b1, 1'b1, 4'b0000, 4'b0000);
    check("R3 transition after long run", 1'b1, 1'b0);

    // R1: beat presented during reset has no effect, history cleared
    rst = 1'b1;
    drive(1'b1, 1'b1, 4'b1111, 4'b0000);
    check("R1 beat during reset ignored", 1'b0, 1'b0);
    rst = 1'b0;
    drive(1'b1, 1'b1, 4'b0001, 4'b0000);
    check("R10 unprimed again after reset", 1'b1, 1'b0);
    drive(1'b0, 1'b1, 4'b0000, 4'b0000);
    check("R7 idle after sequence", 1'b0, 1'b0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule